// File: doc/BRIEF.md
# Highest-Set-Bit Priority Encoder with Runtime Width

This block takes a data word of up to `DATA_W` bits together with a runtime width value. It reports the position of the most significant asserted bit within the low `width` bits, where the highest-numbered bit has top priority. It also reports the number of leading zeros within that width, and a flag that says whether any bit was set. The same hardware serves any active width from 1 to `DATA_W`, so one instance covers request vectors of different sizes.

The block does not use a comparator tree or a casez chain. Every bit below the topmost set bit is first filled with ones by OR-ing the word with right-shifted copies of itself, with shifts of 1, 2, 4 and so on. The resulting run of ones is then counted by a mask-and-add population counter. The leading-zero count is the width minus that count, and the index is the count minus one. One register stage captures the results on the clock edge after an accepted input.

Top module: `hb_prio_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `out_found`, `out_lzc` and `out_index` are all cleared to zero.
- R2: `out_valid` is high in the cycle after a cycle where `in_valid` was high, and low in the cycle after a cycle where it was low.
- R3: `out_index` is the position of the most significant 1 among bits 0 to width-1 of `in_data`. Bits at positions width and above have no effect.
- R4: The effective width is `in_size` if it lies between 1 and `DATA_W`. A value of 0, or any value above `DATA_W`, is treated as `DATA_W`.
- R5: `out_lzc` equals the effective width minus (`out_index` + 1) whenever a bit is found.
- R6: If no bit is set within the effective width, then `out_found` is 0, `out_lzc` equals the effective width and `out_index` is 0.
- R7: With a width of 4, any word with bit 3 set gives index 3. The word 0110 gives index 2, so index bit 0 is 0 even though input bit 1 is set. The word 0010 gives a leading-zero count of 2 and an index of 1.
- R8: While `in_valid` is low, `out_found`, `out_lzc` and `out_index` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and width are presented this cycle |
| in_data | input | DATA_W | Request word, bit DATA_W-1 has the highest priority |
| in_size | input | SIZE_W | Runtime active width, clamped per R4 |
| out_valid | output | 1 | Result registers hold a fresh result |
| out_found | output | 1 | At least one bit set within the width |
| out_lzc | output | SIZE_W | Leading zeros within the width |
| out_index | output | IDX_W | Position of the highest set bit |

## Verification
Every one-hot word at full width and at a mid-range width is applied. This shows whether each bit position maps to its own index, and whether bits past the width are dropped. All-ones and all-zero words are also applied: the first shows that lower bits never disturb the top bit, and the second shows the no-bit case with its leading-zero count equal to the width. The worked width-4 words separate a true priority encoder from a plain OR of inputs. Random words with shifted sparsity and random widths, including widths of 0 and widths above `DATA_W`, test the clamp. Idle gaps between inputs check that the outputs are held.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned HB_DATA_W = 64;
  localparam int unsigned HB_LG     = $clog2(HB_DATA_W);
  localparam int unsigned HB_SIZE_W = HB_LG + 1;
  localparam int unsigned HB_IDX_W  = HB_LG;
endpackage

// File: rtl/hb_smear.sv
module hb_smear #(
  parameter int unsigned DATA_W = hb_pkg::HB_DATA_W,
  parameter int unsigned SIZE_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic [SIZE_W-1:0] eff_size,
  output logic [DATA_W-1:0] masked,
  output logic [DATA_W-1:0] smeared
);
  localparam int unsigned LG = $clog2(DATA_W);

  // keep only bit positions below the active width
  function automatic logic [DATA_W-1:0] width_mask(input logic [SIZE_W-1:0] w);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (SIZE_W'(i) < w);
    return m;
  endfunction

  // push the highest 1 downward into every lower position
  function automatic logic [DATA_W-1:0] fill_down(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] v;
    v = x;
    for (int s = 0; s < LG; s++) v = v | (v >> (1 << s));
    return v;
  endfunction

  assign masked  = in_data & width_mask(eff_size);
  assign smeared = fill_down(masked);
endmodule

// File: rtl/hb_popcount.sv
module hb_popcount #(
  parameter int unsigned DATA_W = hb_pkg::HB_DATA_W,
  parameter int unsigned CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] word,
  output logic [CNT_W-1:0]  count
);
  localparam int unsigned LG = $clog2(DATA_W);

  // repeating pattern: w ones, then w zeros
  function automatic logic [DATA_W-1:0] rep_mask(input int unsigned w);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i % (2 * w)) < w);
    return m;
  endfunction

  localparam logic [DATA_W-1:0] M_PAIR = rep_mask(1);
  localparam logic [DATA_W-1:0] M_NIB  = rep_mask(2);
  localparam logic [DATA_W-1:0] M_BYTE = rep_mask(4);

  function automatic logic [CNT_W-1:0] ones(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] v;
    v = x - ((x >> 1) & M_PAIR);
    v = ((v >> 2) & M_NIB) + (v & M_NIB);
    v = ((v >> 4) + v) & M_BYTE;
    for (int s = 3; s < LG; s++) v = v + (v >> (1 << s));
    return v[CNT_W-1:0];
  endfunction

  assign count = ones(word);
endmodule

// File: rtl/hb_index_calc.sv
module hb_index_calc #(
  parameter int unsigned SIZE_W = hb_pkg::HB_SIZE_W,
  parameter int unsigned IDX_W  = hb_pkg::HB_IDX_W
) (
  input  logic [SIZE_W-1:0] eff_size,
  input  logic [SIZE_W-1:0] ones_cnt,
  output logic [SIZE_W-1:0] lzc,
  output logic [IDX_W-1:0]  index,
  output logic              found
);
  // width - 1 - lzc, narrowed to the index field; only used when found
  function automatic logic [IDX_W-1:0] pos_of(input logic [SIZE_W-1:0] w,
                                              input logic [SIZE_W-1:0] z);
    logic [SIZE_W-1:0] p;
    p = w - SIZE_W'(1) - z;
    return p[IDX_W-1:0];
  endfunction

  assign lzc   = eff_size - ones_cnt;
  assign found = (ones_cnt != '0);
  assign index = found ? pos_of(eff_size, lzc) : '0;
endmodule

// File: rtl/hb_prio_encoder.sv
module hb_prio_encoder #(
  parameter int unsigned DATA_W = hb_pkg::HB_DATA_W,
  parameter int unsigned SIZE_W = $clog2(DATA_W) + 1,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SIZE_W-1:0] in_size,
  output logic              out_valid,
  output logic              out_found,
  output logic [SIZE_W-1:0] out_lzc,
  output logic [IDX_W-1:0]  out_index
);
  localparam logic [SIZE_W-1:0] FULL = SIZE_W'(DATA_W);

  function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] s);
    return (s == '0 || s > FULL) ? FULL : s;
  endfunction

  // named internal events, visible to the assertions
  logic [SIZE_W-1:0] eff_size;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] smeared;
  logic [SIZE_W-1:0] pop_cnt;
  logic [SIZE_W-1:0] nxt_lzc;
  logic [IDX_W-1:0]  nxt_index;
  logic              nxt_found;

  assign eff_size = clamp_size(in_size);

  hb_smear #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_smear (
    .in_data (in_data),
    .eff_size(eff_size),
    .masked  (masked),
    .smeared (smeared)
  );

  hb_popcount #(.DATA_W(DATA_W), .CNT_W(SIZE_W)) u_pop (
    .word (smeared),
    .count(pop_cnt)
  );

  hb_index_calc #(.SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_idx (
    .eff_size(eff_size),
    .ones_cnt(pop_cnt),
    .lzc     (nxt_lzc),
    .index   (nxt_index),
    .found   (nxt_found)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_found <= 1'b0;
      out_lzc   <= '0;
      out_index <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_found <= nxt_found;
        out_lzc   <= nxt_lzc;
        out_index <= nxt_index;
      end
    end
  end

  // R3: masking leaves nothing at or above the width
  a_r3_mask_bound: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((masked >> eff_size) == '0));
  // R3: smearing yields one unbroken run of ones from bit 0
  a_r3_smear_run: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((smeared & (smeared + 1'b1)) == '0));
  // R5: the population count never exceeds the width
  a_r5_count_le_width: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (pop_cnt <= eff_size));
  // R6: an empty masked word gives the no-bit result
  a_r6_empty_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && masked == '0) |=> (!out_found && out_index == '0));
  // R2: output valid follows input valid by one cycle
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_drop: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: results hold while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_found) && $stable(out_lzc) && $stable(out_index)));
  // R4: leading-zero count stays within the clamped width
  a_r4_lzc_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_lzc <= FULL));
endmodule

// File: tb/sim_hb_prio_encoder.sv
`timescale 1ns/1ps
module sim_hb_prio_encoder;
  localparam int DW = 64;
  localparam int SW = 7;
  localparam int IW = 6;

  typedef struct {
    logic          found;
    logic [SW-1:0] lzc;
    logic [IW-1:0] idx;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [SW-1:0] in_size = '0;
  logic          out_valid, out_found;
  logic [SW-1:0] out_lzc;
  logic [IW-1:0] out_index;

  int   errors = 0;
  int   checks = 0;
  exp_t q[$];
  exp_t last;

  always #4 clk = ~clk;

  hb_prio_encoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_size(in_size), .out_valid(out_valid), .out_found(out_found),
    .out_lzc(out_lzc), .out_index(out_index)
  );

  // reference: scan downward from the top of the clamped width
  function automatic exp_t model(input logic [DW-1:0] d, input int sz, input string tag);
    exp_t e;
    int w;
    w = (sz == 0 || sz > DW) ? DW : sz;
    e.found = 1'b0; e.idx = '0; e.lzc = SW'(w); e.tag = tag;
    for (int i = w - 1; i >= 0; i--) begin
      if (d[i]) begin
        e.found = 1'b1; e.idx = IW'(i); e.lzc = SW'(w - 1 - i);
        break;
      end
    end
    return e;
  endfunction

  task automatic send(input logic [DW-1:0] d, input int sz, input string tag);
    in_valid = 1'b1; in_data = d; in_size = SW'(sz);
    q.push_back(model(d, sz, tag));
    last = q[$];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_data  = {$urandom, $urandom};
    in_size  = SW'($urandom);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each produced result with the queue front
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_valid) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R2: out_valid=1 actual, expected 0 (no pending item)");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (out_found !== e.found || out_lzc !== e.lzc || out_index !== e.idx) begin
            errors++;
            $display("FAIL %s: found/lzc/idx actual %0b/%0d/%0d expected %0b/%0d/%0d",
                     e.tag, out_found, out_lzc, out_index, e.found, e.lzc, e.idx);
          end
        end
      end
    end
  end

  task automatic check_hold(input string tag);
    #2;
    checks++;
    if (out_valid !== 1'b0 || out_found !== last.found || out_lzc !== last.lzc ||
        out_index !== last.idx) begin
      errors++;
      $display("FAIL %s: valid/found/lzc/idx actual %0b/%0b/%0d/%0d expected 0/%0b/%0d/%0d",
               tag, out_valid, out_found, out_lzc, out_index, last.found, last.lzc, last.idx);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if (out_valid !== 1'b0 || out_found !== 1'b0 || out_lzc !== '0 || out_index !== '0) begin
      errors++;
      $display("FAIL R1: valid/found/lzc/idx actual %0b/%0b/%0d/%0d expected 0/0/0/0",
               out_valid, out_found, out_lzc, out_index);
    end
    rst = 1'b0;
    idle(2);

    // R7 worked width-4 cases
    send(64'b0010, 4, "R7");
    send(64'b0110, 4, "R7");
    for (int v = 8; v < 16; v++) send(DW'(v), 4, "R7");
    send(64'hF0, 4, "R3");
    idle(3);
    check_hold("R8");

    // single-bit patterns at full and mid width
    for (int b = 0; b < DW; b++) send(DW'(1) << b, 64, "R5");
    for (int b = 0; b < DW; b++) send(DW'(1) << b, 37, "R3");
    idle(2);

    // all zero and all ones
    send('0, 1, "R6");
    send('0, 64, "R6");
    send('0, 20, "R6");
    send(DW'(1) << 40, 20, "R6");
    send('1, 5, "R3");
    send('1, 1, "R3");
    idle(4);
    check_hold("R8");

    // out-of-range widths
    send(DW'(1) << 63, 0, "R4");
    send(DW'(1) << 50, 100, "R4");
    send('0, 127, "R4");
    send(64'h0000_0100_0000_0001, 65, "R4");
    idle(1);

    // random words, random widths, random gaps
    for (int n = 0; n < 400; n++) begin
      logic [DW-1:0] d;
      d = {$urandom, $urandom} >> ($urandom % 64);
      send(d, int'($urandom % 128), "R3");
      if ($urandom % 4 == 0) idle(int'($urandom % 3) + 1);
    end
    idle(3);
    check_hold("R8");

    checks++; // R2: every input produced exactly one result
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending results actual %0d expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule